// File: doc/BRIEF.md
# Interrupt-Then-Reset Watchdog Core

This block is a watchdog that counts a slow tick supplied by the surrounding clock logic. A three-bit period select chooses a power-of-two timeout length. The counter runs while the block is enabled. When the chosen number of ticks has elapsed, the core does not reset the system straight away. It first raises a timeout interrupt and a wakeup flag, and then opens a grace window of 1026 ticks. If software clears the counter inside that window, nothing further happens. If it does not, and reset generation is enabled, the core drives a registered system-reset pulse of fixed length and records in a sticky flag that the watchdog caused the reset.

Software services the watchdog with a single-cycle clear strobe. It clears each status flag separately by pulsing that flag's acknowledge input. Dropping the enable stops all activity and keeps the configuration inputs untouched. Raising the enable again starts a fresh period.

Top module: `wdog_core`

## Requirements
- R1: With select value n (0 to 7) on `tsel_i`, a timeout occurs on exactly the 2^(4+2n) th cycle with `tick_i` high after the counter was last zeroed; cycles with `tick_i` low are not counted.
- R2: A timeout sets both `irq_flag_o` and `wake_flag_o` on the next clock edge. A one-cycle pulse on `ack_irq_i` clears only the interrupt flag, and one on `ack_wake_i` clears only the wakeup flag. When a set and an acknowledge fall in the same cycle, the set wins.
- R3: `irq_o` is high exactly when `irq_flag_o` is high and `irq_en_i` is high.
- R4: With `rst_en_i` high, `sys_rst_o` rises on the clock edge that consumes the 1026th tick after the timeout, provided no clear, disable or reset intervened.
- R5: `clr_i` zeroes the period counter and cancels a running grace window. A tick arriving in the same cycle as `clr_i` is not counted.
- R6: With `rst_en_i` low, the grace window runs out without any pulse on `sys_rst_o`.
- R7: While `en_i` is low, ticks are ignored, the counter is held at zero and any grace window is cancelled. After `en_i` returns high, a full period must elapse before the next timeout.
- R8: `sys_rst_o` stays high for exactly PULSE_LEN cycles (default 4). The counter is held at zero during the pulse, so the next timeout needs a full period.
- R9: `cause_flag_o` is set on the same edge that raises `sys_rst_o`. It stays set until a pulse on `ack_cause_i` or a block reset.
- R10: After `rst_n` has been low, all three flags, `irq_o` and `sys_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle slow count tick |
| en_i | input | 1 | Watchdog enable |
| irq_en_i | input | 1 | Interrupt output enable |
| rst_en_i | input | 1 | System reset generation enable |
| tsel_i | input | 3 | Period select n, period 2^(4+2n) ticks |
| clr_i | input | 1 | Counter clear strobe |
| ack_irq_i | input | 1 | Clear interrupt flag |
| ack_wake_i | input | 1 | Clear wakeup flag |
| ack_cause_i | input | 1 | Clear reset-cause flag |
| irq_o | output | 1 | Gated timeout interrupt |
| sys_rst_o | output | 1 | Registered system reset pulse |
| irq_flag_o | output | 1 | Timeout interrupt flag |
| wake_flag_o | output | 1 | Timeout wakeup flag |
| cause_flag_o | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The period is measured for random select values from 0 to 3, with random idle gaps placed between ticks. This separates counting ticks from counting clock cycles and catches a wrong exponent step. Directed cases count the grace window tick by tick and time the reset pulse cycle by cycle. They also place a clear in the middle of the grace window and put a tick and a clear in the same cycle, which shows whether clear really has priority. Further cases turn off the enable during the grace window, drop the reset enable, and acknowledge each flag alone, so that a mistake in one flag cannot be hidden by a neighbouring flag.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog core.
// Assumes: all users share one clock domain; tick arrives as a one-cycle enable.
package wdog_pkg;

    // Controller phase: counting, waiting in the grace window, driving reset
    typedef enum logic [1:0] {
        WD_RUN   = 2'd0,
        WD_GRACE = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

    // Exponent of the shortest period and the step per select value
    localparam int unsigned WD_BASE_EXP = 4;
    localparam int unsigned WD_EXP_STEP = 2;

    // Flag slot positions inside the flag vector
    localparam int unsigned WD_F_IRQ   = 0;
    localparam int unsigned WD_F_WAKE  = 1;
    localparam int unsigned WD_F_CAUSE = 2;
    localparam int unsigned WD_NFLAGS  = 3;

endpackage

// File: rtl/wdog_period_cnt.sv
// Period counter: counts ticks and reports a timeout on the last tick of the
// selected power-of-two period.
// Assumes: run is low whenever the core is disabled or driving reset;
// clr has priority over a tick in the same cycle.
module wdog_period_cnt #(
    parameter int unsigned TSEL_W = 3,
    parameter int unsigned CNT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              tick,
    input  logic [TSEL_W-1:0] tsel,
    output logic              timeout
);
    import wdog_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W:0]   one_shift;
    int unsigned      shamt;

    // Purpose: derive the final count value of the selected period
    always_comb begin
        shamt     = WD_BASE_EXP + WD_EXP_STEP * int'(tsel);
        one_shift = (CNT_W+1)'(1) << shamt;
        last_val  = one_shift[CNT_W-1:0] - CNT_W'(1);
    end

    // Purpose: flag the tick that completes the period
    always_comb begin
        timeout = run && !clr && tick && (cnt_q == last_val);
    end

    // Purpose: hold, clear or advance the tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == last_val) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdog_grace.sv
// Grace and reset controller: after a timeout, waits GRACE_TICKS ticks and
// then, if allowed, drives a reset pulse of PULSE_LEN cycles.
// Assumes: timeout is only high while enabled and not clearing.
module wdog_grace #(
    parameter int unsigned GRACE_TICKS = 1026,
    parameter int unsigned PULSE_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    input  logic timeout,
    input  logic rst_en,
    output logic fire,
    output logic in_pulse
);
    import wdog_pkg::*;

    localparam int unsigned GW = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;
    localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(GRACE_TICKS - 1);
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_LEN - 1);

    wd_state_e     st_q;
    logic [GW-1:0] gcnt_q;
    logic [PW-1:0] pcnt_q;
    logic          g_end;

    // Purpose: detect the tick that closes the grace window
    always_comb begin
        g_end = (st_q == WD_GRACE) && en && !clr && tick && (gcnt_q == G_LAST);
    end

    // Purpose: expose reset launch and the active pulse
    always_comb begin
        fire     = g_end && rst_en;
        in_pulse = (st_q == WD_PULSE);
    end

    // Purpose: step the grace and pulse sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WD_RUN;
            gcnt_q <= '0;
            pcnt_q <= '0;
        end else begin
            case (st_q)
                WD_RUN: begin
                    if (timeout) begin
                        st_q   <= WD_GRACE;
                        gcnt_q <= '0;
                    end
                end
                WD_GRACE: begin
                    if (!en || clr) begin
                        st_q <= WD_RUN;
                    end else if (g_end) begin
                        pcnt_q <= '0;
                        gcnt_q <= '0;
                        if (rst_en) begin
                            st_q <= WD_PULSE;
                        end else if (timeout) begin
                            st_q <= WD_GRACE;
                        end else begin
                            st_q <= WD_RUN;
                        end
                    end else if (tick) begin
                        gcnt_q <= gcnt_q + GW'(1);
                    end
                end
                WD_PULSE: begin
                    if (pcnt_q == P_LAST) begin
                        st_q <= WD_RUN;
                    end else begin
                        pcnt_q <= pcnt_q + PW'(1);
                    end
                end
                default: st_q <= WD_RUN;
            endcase
        end
    end

endmodule

// File: rtl/wdog_flags.sv
// Status flags: each bit is set by its event and cleared by its acknowledge.
// Assumes: a set and an acknowledge in the same cycle leave the flag set.
module wdog_flags #(
    parameter int unsigned NFLAGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set,
    input  logic [NFLAGS-1:0] ack,
    output logic [NFLAGS-1:0] flags
);
    for (genvar gi = 0; gi < NFLAGS; gi++) begin : g_flag
        // Purpose: one sticky write-one-to-clear bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[gi] <= 1'b0;
            end else if (set[gi]) begin
                flags[gi] <= 1'b1;
            end else if (ack[gi]) begin
                flags[gi] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdog_core.sv
// Watchdog core top: period counter, grace/reset controller and flags.
// Assumes: tick_i is a single-cycle enable synchronous to clk; the reset
// pulse does not feed back into rst_n, so the cause flag survives it.
module wdog_core #(
    parameter int unsigned TSEL_W      = 3,
    parameter int unsigned GRACE_TICKS = 1026,
    parameter int unsigned PULSE_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              irq_en_i,
    input  logic              rst_en_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              clr_i,
    input  logic              ack_irq_i,
    input  logic              ack_wake_i,
    input  logic              ack_cause_i,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic              irq_flag_o,
    output logic              wake_flag_o,
    output logic              cause_flag_o
);
    import wdog_pkg::*;

    localparam int unsigned CNT_W = WD_BASE_EXP + WD_EXP_STEP * ((2 ** TSEL_W) - 1);

    logic                 run;
    logic                 timeout;
    logic                 fire;
    logic                 in_pulse;
    logic [WD_NFLAGS-1:0] f_set;
    logic [WD_NFLAGS-1:0] f_ack;
    logic [WD_NFLAGS-1:0] f_q;

    // Purpose: counter only runs while enabled and not driving reset
    always_comb begin
        run = en_i && !in_pulse;
    end

    wdog_period_cnt #(
        .TSEL_W (TSEL_W),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (clr_i),
        .tick    (tick_i),
        .tsel    (tsel_i),
        .timeout (timeout)
    );

    wdog_grace #(
        .GRACE_TICKS (GRACE_TICKS),
        .PULSE_LEN   (PULSE_LEN)
    ) u_grace (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .clr      (clr_i),
        .tick     (tick_i),
        .timeout  (timeout),
        .rst_en   (rst_en_i),
        .fire     (fire),
        .in_pulse (in_pulse)
    );

    // Purpose: route events and acknowledges to their flag slots
    always_comb begin
        f_set             = '0;
        f_ack             = '0;
        f_set[WD_F_IRQ]   = timeout;
        f_set[WD_F_WAKE]  = timeout;
        f_set[WD_F_CAUSE] = fire;
        f_ack[WD_F_IRQ]   = ack_irq_i;
        f_ack[WD_F_WAKE]  = ack_wake_i;
        f_ack[WD_F_CAUSE] = ack_cause_i;
    end

    wdog_flags #(
        .NFLAGS (WD_NFLAGS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (f_set),
        .ack   (f_ack),
        .flags (f_q)
    );

    // Purpose: drive the outputs from flags and controller state
    always_comb begin
        irq_flag_o   = f_q[WD_F_IRQ];
        wake_flag_o  = f_q[WD_F_WAKE];
        cause_flag_o = f_q[WD_F_CAUSE];
        irq_o        = f_q[WD_F_IRQ] && irq_en_i;
        sys_rst_o    = in_pulse;
    end

endmodule

// File: rtl/wdog_core_chk.sv
// Property checker for the watchdog core, attached by bind.
// Assumes: it only observes ports of the top module.
module wdog_core_chk #(
    parameter int unsigned PULSE_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic irq_en_i,
    input logic rst_en_i,
    input logic clr_i,
    input logic ack_irq_i,
    input logic irq_o,
    input logic sys_rst_o,
    input logic irq_flag_o,
    input logic wake_flag_o,
    input logic cause_flag_o
);
    localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;

    logic [HW-1:0] hi_cnt;

    // Purpose: count cycles the reset output has already been high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (sys_rst_o) begin
            if (hi_cnt < HW'(PULSE_LEN)) hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(rst_en_i)); // R6

    AST_CAUSE_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> cause_flag_o); // R9

    AST_WAKE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> wake_flag_o); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !ack_irq_i) |=> irq_flag_o); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o); // R3

    AST_CLR_BLOCKS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || !en_i) |=> !$rose(sys_rst_o)); // R5

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (hi_cnt < HW'(PULSE_LEN))); // R8

    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> ($past(hi_cnt) == HW'(PULSE_LEN - 1))); // R8

endmodule

bind wdog_core wdog_core_chk #(
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .irq_en_i     (irq_en_i),
    .rst_en_i     (rst_en_i),
    .clr_i        (clr_i),
    .ack_irq_i    (ack_irq_i),
    .irq_o        (irq_o),
    .sys_rst_o    (sys_rst_o),
    .irq_flag_o   (irq_flag_o),
    .wake_flag_o  (wake_flag_o),
    .cause_flag_o (cause_flag_o)
);

// File: tb/wdog_core_bench.sv
// Self-checking bench for the watchdog core: random periods plus directed
// grace, clear, enable and flag cases.
module wdog_core_bench;

    localparam int GRACE = 1026;
    localparam int PLEN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       en_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic       rst_en_i = 1'b0;
    logic [2:0] tsel_i = 3'd0;
    logic       clr_i = 1'b0;
    logic       ack_irq_i = 1'b0;
    logic       ack_wake_i = 1'b0;
    logic       ack_cause_i = 1'b0;
    logic       irq_o;
    logic       sys_rst_o;
    logic       irq_flag_o;
    logic       wake_flag_o;
    logic       cause_flag_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int rst_hi = 0;

    wdog_core u_wdog_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .en_i         (en_i),
        .irq_en_i     (irq_en_i),
        .rst_en_i     (rst_en_i),
        .tsel_i       (tsel_i),
        .clr_i        (clr_i),
        .ack_irq_i    (ack_irq_i),
        .ack_wake_i   (ack_wake_i),
        .ack_cause_i  (ack_cause_i),
        .irq_o        (irq_o),
        .sys_rst_o    (sys_rst_o),
        .irq_flag_o   (irq_flag_o),
        .wake_flag_o  (wake_flag_o),
        .cause_flag_o (cause_flag_o)
    );

    always #10 clk = ~clk;

    // Reset-output cycle count and watchdog on the run
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sys_rst_o) rst_hi = rst_hi + 1;
        if (cyc == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic int period_of(input int sel);
        return 1 << (4 + 2 * sel);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One tick after gap idle cycles; returns at a negedge after it is consumed
    task automatic tick1(input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) tick1(0);
    endtask

    task automatic strobe_clr;
        @(negedge clk) clr_i = 1'b1;
        @(negedge clk) clr_i = 1'b0;
    endtask

    task automatic ack_all;
        @(negedge clk) begin ack_irq_i = 1; ack_wake_i = 1; ack_cause_i = 1; end
        @(negedge clk) begin ack_irq_i = 0; ack_wake_i = 0; ack_cause_i = 0; end
    endtask

    task automatic to_irq(input int limit, input bit rnd, output int n);
        n = 0;
        while (!irq_flag_o && n < limit) begin
            tick1(rnd ? int'($urandom_range(0, 2)) : 0);
            n = n + 1;
        end
    endtask

    task automatic to_rst(input int limit, output int n);
        n = 0;
        while (!sys_rst_o && n < limit) begin
            tick1(0);
            n = n + 1;
        end
    endtask

    initial begin
        int n;
        int base;
        void'($urandom(32'd4242));

        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!irq_flag_o && !wake_flag_o && !cause_flag_o && !irq_o && !sys_rst_o,
              "R10 reset state", {irq_flag_o, wake_flag_o, cause_flag_o, irq_o, sys_rst_o}, 0);

        // R1: random periods with random tick gaps
        en_i = 1'b1;
        for (int t = 0; t < 8; t++) begin
            int sel;
            sel = int'($urandom_range(0, 3));
            tsel_i = 3'(sel);
            ack_all();
            strobe_clr();
            to_irq(period_of(sel) + 4, 1'b1, n);
            check(n == period_of(sel), "R1 period", n, period_of(sel));
        end

        // R2: both flags set; independent acknowledge
        check(wake_flag_o, "R2 wake set with irq", wake_flag_o, 1);
        @(negedge clk) ack_irq_i = 1'b1;
        @(negedge clk) ack_irq_i = 1'b0;
        check(!irq_flag_o && wake_flag_o, "R2 irq ack alone", {irq_flag_o, wake_flag_o}, 1);
        @(negedge clk) ack_wake_i = 1'b1;
        @(negedge clk) ack_wake_i = 1'b0;
        check(!wake_flag_o, "R2 wake ack", wake_flag_o, 0);

        // R2: set wins over ack in the same cycle
        tsel_i = 3'd0;
        strobe_clr();
        ticks(15);
        @(negedge clk) begin tick_i = 1'b1; ack_irq_i = 1'b1; end
        @(negedge clk) begin tick_i = 1'b0; ack_irq_i = 1'b0; end
        check(irq_flag_o, "R2 set beats ack", irq_flag_o, 1);

        // R3: interrupt gating
        irq_en_i = 1'b0;
        @(negedge clk);
        check(!irq_o, "R3 masked", irq_o, 0);
        irq_en_i = 1'b1;
        @(negedge clk);
        check(irq_o, "R3 unmasked", irq_o, 1);
        ack_all();
        @(negedge clk);
        check(!irq_o, "R3 flag clear", irq_o, 0);

        // R5: clear beats tick in the same cycle
        strobe_clr();
        ticks(15);
        @(negedge clk) begin tick_i = 1'b1; clr_i = 1'b1; end
        @(negedge clk) begin tick_i = 1'b0; clr_i = 1'b0; end
        check(!irq_flag_o, "R5 clr beats tick", irq_flag_o, 0);
        to_irq(40, 1'b0, n);
        check(n == 16, "R5 restart after clr", n, 16);

        // R4, R8, R9: grace expiry with reset enabled
        rst_en_i = 1'b1;
        tsel_i = 3'd3;
        ack_all();
        strobe_clr();
        to_irq(1100, 1'b0, n);
        check(n == 1024, "R1 period sel3", n, 1024);
        to_rst(GRACE + 10, n);
        check(n == GRACE, "R4 grace length", n, GRACE);
        check(cause_flag_o, "R9 cause set with reset", cause_flag_o, 1);
        n = 1;
        while (n < 20) begin
            @(negedge clk);
            if (sys_rst_o) n = n + 1; else break;
        end
        check(n == PLEN, "R8 pulse length", n, PLEN);
        ticks(50);
        check(cause_flag_o, "R9 cause sticky", cause_flag_o, 1);
        @(negedge clk) ack_irq_i = 1'b1;
        @(negedge clk) begin ack_irq_i = 1'b0; ack_wake_i = 1'b1; end
        @(negedge clk) ack_wake_i = 1'b0;
        check(cause_flag_o, "R9 cause kept by other acks", cause_flag_o, 1);
        @(negedge clk) ack_cause_i = 1'b1;
        @(negedge clk) ack_cause_i = 1'b0;
        check(!cause_flag_o, "R9 cause ack", cause_flag_o, 0);
        // R8: counter restarted from zero at pulse end (50 ticks already used)
        to_irq(1100, 1'b0, n);
        check(n == 1024 - 50, "R8 restart after pulse", n, 1024 - 50);

        // R5: clear inside grace cancels reset
        ack_all();
        strobe_clr();
        to_irq(1100, 1'b0, n);
        base = rst_hi;
        ticks(500);
        strobe_clr();
        ticks(1000);
        check(rst_hi == base, "R5 clr cancels grace", rst_hi - base, 0);

        // R7: disable inside grace cancels reset, then full period needed
        ack_all();
        strobe_clr();
        to_irq(1100, 1'b0, n);
        base = rst_hi;
        ticks(600);
        @(negedge clk) en_i = 1'b0;
        ticks(30);
        @(negedge clk) en_i = 1'b1;
        ticks(600);
        check(rst_hi == base, "R7 disable cancels grace", rst_hi - base, 0);

        // R7: ticks ignored while disabled; restart from zero
        tsel_i = 3'd0;
        ack_all();
        strobe_clr();
        ticks(10);
        @(negedge clk) en_i = 1'b0;
        ticks(40);
        check(!irq_flag_o, "R7 ticks ignored when off", irq_flag_o, 0);
        @(negedge clk) en_i = 1'b1;
        to_irq(40, 1'b0, n);
        check(n == 16, "R7 full period after enable", n, 16);

        // R6: no reset when reset generation is off
        rst_en_i = 1'b0;
        tsel_i = 3'd3;
        ack_all();
        strobe_clr();
        to_irq(1100, 1'b0, n);
        base = rst_hi;
        ticks(1100);
        check(rst_hi == base && !cause_flag_o, "R6 no reset when off", rst_hi - base, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule